// File: doc/BRIEF.md
# Framed Serial Trigger-Word Transmitter

This block feeds trigger information to a processor over two independent synchronous serial links clocked at 40 MHz. The first link sends one combined frame per trigger: a 12-bit bunch-crossing number, then a 32-bit event number, under a single frame-sync pulse. The second link sends one 8-bit trigger-type word per frame. On both links every field leaves most significant bit first.

Upstream logic hands each link a parallel word with a one-cycle load strobe. Each word goes into a four-entry queue owned by that link. A per-link sequencer takes words from its queue and emits a frame-sync pulse followed by the data bits. It then holds the line quiet for a minimum gap before the next frame may start. A full queue raises a busy flag, and a load presented while that flag is high is discarded.

Top module: `trig_serial_tx`

## Requirements
- R1: After reset both frame-sync lines and both data lines are low, and both busy flags are low.
- R2: A crossing/event frame is a single-cycle high pulse on `xing_fsync`. The 44 data bits follow on `xing_sdata` in the 44 cycles right after it: the 12-bit crossing number MSB first, then the 32-bit event number MSB first. No further sync pulse occurs inside the frame.
- R3: A trigger-type frame is a single-cycle high pulse on `ttype_fsync`. The 8 trigger-type bits follow on `ttype_sdata`, MSB first, in the 8 cycles right after it.
- R4: A data line is low in every cycle that does not carry a data bit, including the sync cycle.
- R5: On each link at least 2 idle cycles (sync low, no data bit) separate the last data bit of one frame from the next sync pulse.
- R6: When a word is already waiting as a frame ends, the next sync pulse follows after exactly 2 idle cycles.
- R7: Each link queues up to 4 pending words and transmits them in load order. Its busy flag is high exactly while 4 words are pending.
- R8: A load presented while the link's busy flag is high has no effect: that word is never transmitted and the queued words go out unchanged.
- R9: The two links operate independently. Words loaded on both links in the same cycle into idle links produce their sync pulses in the same cycle, and a queue fills without regard to the other link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock (40 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| xing_load | input | 1 | Strobe: queue a crossing/event word |
| xing_num | input | 12 | Bunch-crossing number to queue |
| event_num | input | 32 | Event number to queue |
| xing_busy | output | 1 | Crossing/event queue full |
| ttype_load | input | 1 | Strobe: queue a trigger-type word |
| ttype_val | input | 8 | Trigger type to queue |
| ttype_busy | output | 1 | Trigger-type queue full |
| xing_fsync | output | 1 | Frame sync, crossing/event link |
| xing_sdata | output | 1 | Serial data, crossing/event link |
| ttype_fsync | output | 1 | Frame sync, trigger-type link |
| ttype_sdata | output | 1 | Serial data, trigger-type link |

## Verification
Two things can happen in the same clock edge: the sequencer popping a queued word as a frame launches, and a new word being written, or refused, at the tail of that queue. The bench provokes this by issuing six back-to-back loads on both links at once. The first word is popped at the same edge where the second is written, and the sixth load meets a full queue. The scoreboard judges the outcome: every accepted word must appear exactly once, in order and with tight 2-cycle gaps. The refused word must never reach the serial line, and both links must launch their first frames in the same cycle.

// File: rtl/tstx_pkg.sv
package tstx_pkg;

    localparam int XING_W    = 12;
    localparam int EVENT_W   = 32;
    localparam int TTYPE_W   = 8;
    localparam int XFRAME_W  = XING_W + EVENT_W;
    localparam int QUEUE_DEPTH = 4;
    localparam int MIN_GAP   = 2;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_SYNC,
        LS_SHIFT,
        LS_GAP
    } link_state_e;

    typedef struct packed {
        logic [XING_W-1:0]  xing;
        logic [EVENT_W-1:0] event_id;
    } xing_word_t;

    function automatic logic [XFRAME_W-1:0] pack_xing(input logic [XING_W-1:0] x,
                                                       input logic [EVENT_W-1:0] e);
        xing_word_t w;
        w.xing     = x;
        w.event_id = e;
        return w;
    endfunction

endpackage

// File: rtl/tstx_queue.sv
module tstx_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/tstx_link.sv
module tstx_link
    import tstx_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int GAP   = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         busy,
    output logic         fsync,
    output logic         sdata
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;

    logic [W-1:0]  head;
    logic          empty;
    logic          pop;
    link_state_e   st;
    logic [W-1:0]  sh;
    logic [CW-1:0] bcnt;
    logic [GW-1:0] gcnt;
    logic          gap_done;
    logic          may_launch;

    tstx_queue #(.W(W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (load),
        .din   (word),
        .pop   (pop),
        .dout  (head),
        .empty (empty),
        .full  (busy)
    );

    assign gap_done   = (st == LS_GAP) && (gcnt == GW'(GAP - 1));
    assign may_launch = (st == LS_IDLE) || gap_done;
    assign pop        = may_launch && !empty;

    assign fsync = (st == LS_SYNC);
    assign sdata = (st == LS_SHIFT) && sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LS_IDLE;
            sh   <= '0;
            bcnt <= '0;
            gcnt <= '0;
        end else begin
            case (st)
                LS_IDLE: begin
                    if (pop) begin
                        st <= LS_SYNC;
                        sh <= head;
                    end
                end
                LS_SYNC: begin
                    st   <= LS_SHIFT;
                    bcnt <= '0;
                end
                LS_SHIFT: begin
                    sh   <= sh << 1;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == CW'(W - 1)) begin
                        st   <= LS_GAP;
                        gcnt <= '0;
                    end
                end
                default: begin
                    gcnt <= gcnt + 1'b1;
                    if (gap_done) begin
                        if (pop) begin
                            st <= LS_SYNC;
                            sh <= head;
                        end else begin
                            st <= LS_IDLE;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/trig_serial_tx.sv
module trig_serial_tx
    import tstx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               xing_load,
    input  logic [XING_W-1:0]  xing_num,
    input  logic [EVENT_W-1:0] event_num,
    output logic               xing_busy,
    input  logic               ttype_load,
    input  logic [TTYPE_W-1:0] ttype_val,
    output logic               ttype_busy,
    output logic               xing_fsync,
    output logic               xing_sdata,
    output logic               ttype_fsync,
    output logic               ttype_sdata
);
    logic [XFRAME_W-1:0] xing_word;

    assign xing_word = pack_xing(xing_num, event_num);

    tstx_link #(.W(XFRAME_W), .DEPTH(QUEUE_DEPTH), .GAP(MIN_GAP)) u_xing_link (
        .clk   (clk),
        .rst   (rst),
        .load  (xing_load),
        .word  (xing_word),
        .busy  (xing_busy),
        .fsync (xing_fsync),
        .sdata (xing_sdata)
    );

    tstx_link #(.W(TTYPE_W), .DEPTH(QUEUE_DEPTH), .GAP(MIN_GAP)) u_ttype_link (
        .clk   (clk),
        .rst   (rst),
        .load  (ttype_load),
        .word  (ttype_val),
        .busy  (ttype_busy),
        .fsync (ttype_fsync),
        .sdata (ttype_sdata)
    );

endmodule

// File: rtl/tstx_link_chk.sv
module tstx_link_chk #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int GAP   = 2
) (
    input logic clk,
    input logic rst,
    input logic load,
    input logic busy,
    input logic fsync,
    input logic sdata
);
    int  left;
    int  idle;
    int  pend;
    bit  sent;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= 0;
            idle <= 0;
            pend <= 0;
            sent <= 1'b0;
        end else begin
            if (fsync)          left <= W;
            else if (left != 0) left <= left - 1;
            if (fsync || left != 0) idle <= 0;
            else if (idle < 1000)   idle <= idle + 1;
            if (fsync) sent <= 1'b1;
            pend <= pend + ((load && !busy) ? 1 : 0) - (fsync ? 1 : 0);
        end
    end

    a_r2_sync_single_cycle: assert property (@(posedge clk) disable iff (rst)
        fsync |=> !fsync);

    a_r2_no_sync_in_frame: assert property (@(posedge clk) disable iff (rst)
        (left != 0) |-> !fsync);

    a_r4_sync_cycle_low: assert property (@(posedge clk) disable iff (rst)
        fsync |-> !sdata);

    a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!fsync && left == 0) |-> !sdata);

    a_r5_min_gap: assert property (@(posedge clk) disable iff (rst)
        (fsync && sent) |-> (idle >= GAP));

    a_r7_busy_when_full: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pend >= DEPTH));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        pend <= DEPTH + 1);

endmodule

bind trig_serial_tx tstx_link_chk #(
    .W(tstx_pkg::XFRAME_W), .DEPTH(tstx_pkg::QUEUE_DEPTH), .GAP(tstx_pkg::MIN_GAP)
) u_chk_xing (
    .clk(clk), .rst(rst), .load(xing_load), .busy(xing_busy),
    .fsync(xing_fsync), .sdata(xing_sdata)
);

bind trig_serial_tx tstx_link_chk #(
    .W(tstx_pkg::TTYPE_W), .DEPTH(tstx_pkg::QUEUE_DEPTH), .GAP(tstx_pkg::MIN_GAP)
) u_chk_ttype (
    .clk(clk), .rst(rst), .load(ttype_load), .busy(ttype_busy),
    .fsync(ttype_fsync), .sdata(ttype_sdata)
);

// File: tb/tb_trig_serial_tx.sv
module tb_trig_serial_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xing_load = 1'b0;
    logic [11:0] xing_num = '0;
    logic [31:0] event_num = '0;
    logic        xing_busy;
    logic        ttype_load = 1'b0;
    logic [7:0]  ttype_val = '0;
    logic        ttype_busy;
    logic        xing_fsync, xing_sdata, ttype_fsync, ttype_sdata;

    trig_serial_tx dut (
        .clk(clk), .rst(rst),
        .xing_load(xing_load), .xing_num(xing_num), .event_num(event_num),
        .xing_busy(xing_busy),
        .ttype_load(ttype_load), .ttype_val(ttype_val), .ttype_busy(ttype_busy),
        .xing_fsync(xing_fsync), .xing_sdata(xing_sdata),
        .ttype_fsync(ttype_fsync), .ttype_sdata(ttype_sdata)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint cyc = 0;

    logic [43:0] exp_x[$];
    logic [7:0]  exp_t[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- monitors ----------------
    bit          x_in = 0, x_seen = 0;
    int          x_bits = 0, x_idle = 0, x_tight = 0, x_frames = 0;
    logic [43:0] x_acc = '0;
    longint      x_sync_cyc = -1;
    bit          t_in = 0, t_seen = 0;
    int          t_bits = 0, t_idle = 0, t_tight = 0, t_frames = 0;
    logic [7:0]  t_acc = '0;
    longint      t_sync_cyc = -1;
    int          idle_bad = 0;
    int          sync_bad = 0;

    always @(negedge clk) begin
        if (rst) begin
            x_in = 0; x_idle = 0; x_seen = 0;
        end else if (x_in) begin
            if (xing_fsync) sync_bad++;
            x_acc = {x_acc[42:0], xing_sdata};
            x_bits++;
            if (x_bits == 44) begin
                x_in = 0; x_idle = 0; x_frames++;
                if (exp_x.size() == 0)
                    chk(0, "R8 unexpected crossing frame", 64'(x_acc), 64'(0));
                else begin
                    logic [43:0] e;
                    e = exp_x.pop_front();
                    chk(x_acc == e, "R2/R7 crossing frame content", 64'(x_acc), 64'(e));
                end
            end
        end else if (xing_fsync) begin
            if (xing_sdata !== 1'b0) idle_bad++;
            if (x_seen) begin
                chk(x_idle >= 2, "R5 crossing gap", 64'(x_idle), 64'(2));
                if (x_idle == 2) x_tight++;
            end
            x_seen = 1; x_in = 1; x_bits = 0; x_sync_cyc = cyc;
        end else begin
            if (xing_sdata !== 1'b0) idle_bad++;
            x_idle++;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            t_in = 0; t_idle = 0; t_seen = 0;
        end else if (t_in) begin
            if (ttype_fsync) sync_bad++;
            t_acc = {t_acc[6:0], ttype_sdata};
            t_bits++;
            if (t_bits == 8) begin
                t_in = 0; t_idle = 0; t_frames++;
                if (exp_t.size() == 0)
                    chk(0, "R8 unexpected trigger-type frame", 64'(t_acc), 64'(0));
                else begin
                    logic [7:0] e;
                    e = exp_t.pop_front();
                    chk(t_acc == e, "R3/R7 trigger-type frame content", 64'(t_acc), 64'(e));
                end
            end
        end else if (ttype_fsync) begin
            if (ttype_sdata !== 1'b0) idle_bad++;
            if (t_seen) begin
                chk(t_idle >= 2, "R5 trigger-type gap", 64'(t_idle), 64'(2));
                if (t_idle == 2) t_tight++;
            end
            t_seen = 1; t_in = 1; t_bits = 0; t_sync_cyc = cyc;
        end else begin
            if (ttype_sdata !== 1'b0) idle_bad++;
            t_idle++;
        end
    end

    // ---------------- drivers ----------------
    task automatic drive_both(input bit dx, input logic [11:0] x, input logic [31:0] e,
                              input bit dt, input logic [7:0] t);
        xing_load  = dx;
        xing_num   = x;
        event_num  = e;
        ttype_load = dt;
        ttype_val  = t;
        if (dx && !xing_busy)  exp_x.push_back({x, e});
        if (dt && !ttype_busy) exp_t.push_back(t);
        @(negedge clk);
        xing_load  = 1'b0;
        ttype_load = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000; i++) begin
            if (exp_x.size() == 0 && exp_t.size() == 0 && !x_in && !t_in) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({xing_fsync, xing_sdata, xing_busy} == 3'b000, "R1 crossing link reset",
            64'({xing_fsync, xing_sdata, xing_busy}), 64'(0));
        chk({ttype_fsync, ttype_sdata, ttype_busy} == 3'b000, "R1 trigger-type link reset",
            64'({ttype_fsync, ttype_sdata, ttype_busy}), 64'(0));

        // R9: load both idle links in the same cycle
        drive_both(1, 12'hABC, 32'h1234_5678, 1, 8'hA5);
        drain();
        chk(x_sync_cyc == t_sync_cyc && x_sync_cyc >= 0, "R9 simultaneous sync",
            64'(x_sync_cyc), 64'(t_sync_cyc));

        // R7/R8/R6: six back-to-back loads on both links; the sixth meets a full queue
        for (int i = 0; i < 6; i++) begin
            if (i == 5) begin
                chk(xing_busy === 1'b1, "R7 crossing busy at 4 pending", 64'(xing_busy), 64'(1));
                chk(ttype_busy === 1'b1, "R7 trigger-type busy at 4 pending", 64'(ttype_busy), 64'(1));
            end
            drive_both(1, 12'(12'h100 + i), 32'hC0DE_0000 + 32'(i * 32'h1111), 1, 8'(8'h30 + i));
        end
        drain();
        chk(x_tight >= 4, "R6 crossing back-to-back gaps", 64'(x_tight), 64'(4));
        chk(t_tight >= 4, "R6 trigger-type back-to-back gaps", 64'(t_tight), 64'(4));
        chk(exp_x.size() == 0 && exp_t.size() == 0, "R8 accepted words all sent",
            64'(exp_x.size() + exp_t.size()), 64'(0));

        // Further patterns, spaced loads, independent links
        drive_both(1, 12'hFFF, 32'hFFFF_FFFF, 0, 8'h00);
        repeat (5) @(negedge clk);
        drive_both(0, 12'h000, 32'h0, 1, 8'hFF);
        drive_both(1, 12'h001, 32'h8000_0001, 1, 8'h80);
        repeat (60) @(negedge clk);
        drive_both(1, 12'h555, 32'hAAAA_5555, 1, 8'h01);
        drive_both(1, 12'h800, 32'h0000_0000, 0, 8'h00);
        drain();

        chk(x_frames == 10, "R2 crossing frame count", 64'(x_frames), 64'(10));
        chk(t_frames == 9, "R3 trigger-type frame count", 64'(t_frames), 64'(9));
        chk(idle_bad == 0, "R4 data low outside data bits", 64'(idle_bad), 64'(0));
        chk(sync_bad == 0, "R2 no sync inside a frame", 64'(sync_bad), 64'(0));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule